// File: doc/BRIEF.md
# Descriptor Ring Address Sequencer

This block walks a ring of DMA descriptors held in system memory and produces every address a channel needs to read and retire them. A descriptor is four 32-bit words (16 bytes). After each descriptor the ring may carry a gap of 0 to 7 bus-width words, so descriptors can sit one per cache line. The gap unit is the data bus word, so one gap value gives a different stride on a 32-, 64- or 128-bit bus. Software gives a requested stride in bytes. The block turns it into the 3-bit gap count and flags any stride that the gap field cannot express.

After `start_i` the sequencer holds the ring base as its current address. A tail pointer write tells it how far it may go. It reads the four words of the current descriptor in order and looks at the ownership flag in the last word. If the DMA owns the descriptor, the block presents it with its frame-start and frame-end flags and writes the last word back with ownership cleared. It then advances by one full stride, or wraps to the base after the last descriptor of the ring. A descriptor that the DMA does not own puts the block in a suspended state until the tail pointer is written again. Fetching stops whenever the current address equals the tail pointer. Memory is modelled as a single port: a read issued in one cycle returns its data in the next.

Top module: `dr_ring_seq`

## Requirements
- R1: The gap count `skip_o` is (stride_req_i - 16) / (BUS_W/8), and consecutive descriptors sit 16 + skip_o × (BUS_W/8) bytes apart. With the default 64-bit bus, a 64-byte stride gives skip 6, a 16-byte stride gives skip 0 and a 72-byte stride gives skip 7.
- R2: `cfg_err_o` is high, and `skip_o` reads 0, when the requested stride is below 16, is not 16 plus a whole number of bus words, or needs more than 7 gap words. While `cfg_err_o` is high, no new descriptor fetch starts.
- R3: The ring base and the tail pointer keep only the address bits at and above log2(BUS_W/8). The lower bits are treated as zero.
- R4: A fetch reads the four words at the descriptor address plus 0, 4, 8 and 12, in that order. The descriptor is presented for one cycle on `desc_o`, with word 0 in bits 31:0 and word 3 in bits 127:96. `desc_first_o` equals word 3 bit 29 and `desc_last_o` equals word 3 bit 28.
- R5: A descriptor whose word 3 bit 31 (ownership) is 0 is not presented and is not written. `suspended_o` rises and no memory access occurs until `tail_wr_i` is pulsed. The same descriptor is then fetched again.
- R6: The cycle after a descriptor is presented, the block writes word 3 back to descriptor address + 12 with bit 31 cleared and the other bits unchanged.
- R7: After the write-back the address advances by one stride. Words in the gap are never read or written.
- R8: After `ring_len_i` descriptors the address wraps back to the ring base.
- R9: No fetch starts while the current address equals the tail pointer. Writing a different tail resumes fetching.
- R10: After reset no memory request, no descriptor and no suspension are signalled. `start_i` loads the current address from the ring base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load current address from ring base |
| ring_base_i | input | ADDR_W | Ring base address |
| ring_len_i | input | LEN_W | Number of descriptors in the ring |
| stride_req_i | input | STRIDE_W | Requested descriptor stride in bytes |
| tail_wr_i | input | 1 | Tail pointer write strobe |
| tail_ptr_i | input | ADDR_W | Tail pointer value |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | ADDR_W | Byte address of the 32-bit access |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid the cycle after a read request |
| desc_valid_o | output | 1 | Descriptor presented this cycle |
| desc_addr_o | output | ADDR_W | Address of the current descriptor |
| desc_o | output | 128 | Descriptor words 3..0 |
| desc_first_o | output | 1 | Frame-start flag of the presented descriptor |
| desc_last_o | output | 1 | Frame-end flag of the presented descriptor |
| skip_o | output | 3 | Gap count derived from the requested stride |
| cfg_err_o | output | 1 | Stride not expressible |
| suspended_o | output | 1 | Halted on a descriptor not owned by the DMA |

## Verification
The assertions assume that the stride request, ring base and ring length stay constant while a fetch is in progress. The error check and the address window are sampled only when a fetch starts. They also assume that the memory answers every read on the following cycle. The stimulus changes configuration only after the sequencer has settled at the tail or in suspension, and the memory model in the bench has a fixed one-cycle latency. Random stride requests are applied only while the block is stopped, so they test the gap arithmetic without disturbing a walk.

// File: rtl/dr_pkg.sv
package dr_pkg;
  localparam int DESC_WORDS = 4;
  localparam int DESC_BYTES = 16;
  localparam int OWN_BIT    = 31;
  localparam int FIRST_BIT  = 29;
  localparam int LAST_BIT   = 28;
  localparam int MAX_SKIP   = 7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_CAP, ST_SHOW, ST_WB, ST_SUSP
  } dr_state_e;
endpackage

// File: rtl/dr_stride_cfg.sv
module dr_stride_cfg #(
  parameter int ADDR_W   = 32,
  parameter int BUS_W    = 64,
  parameter int STRIDE_W = 8
) (
  input  logic [STRIDE_W-1:0] stride_req_i,
  output logic [2:0]          skip_o,
  output logic [ADDR_W-1:0]   stride_o,
  output logic                err_o
);
  localparam int AL = $clog2(BUS_W / 8);

  logic [STRIDE_W-1:0] extra;
  logic [STRIDE_W-1:0] words;

  always_comb begin
    extra  = stride_req_i - STRIDE_W'(dr_pkg::DESC_BYTES);
    words  = extra >> AL;
    err_o  = (stride_req_i < STRIDE_W'(dr_pkg::DESC_BYTES)) ||
             (extra[AL-1:0] != '0) ||
             (words > STRIDE_W'(dr_pkg::MAX_SKIP));
    skip_o = err_o ? 3'd0 : words[2:0];
    // stride rebuilt from the field as the hardware would decode it
    stride_o = ADDR_W'(dr_pkg::DESC_BYTES) + (ADDR_W'(skip_o) << AL);
  end
endmodule

// File: rtl/dr_addr_gen.sv
module dr_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8,
  parameter int AL     = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [ADDR_W-1:0] stride_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] base_al;
  logic [LEN_W-1:0]  idx_q;
  logic              last;

  assign base_al = {base_i[ADDR_W-1:AL], {AL{1'b0}}};
  assign last    = ({1'b0, idx_q} + 1'b1) >= {1'b0, len_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      idx_q  <= '0;
    end else if (load_i) begin
      addr_o <= base_al;
      idx_q  <= '0;
    end else if (adv_i) begin
      if (last) begin
        addr_o <= base_al;
        idx_q  <= '0;
      end else begin
        addr_o <= addr_o + stride_i;
        idx_q  <= idx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dr_ring_seq.sv
module dr_ring_seq #(
  parameter int ADDR_W   = 32,
  parameter int BUS_W    = 64,
  parameter int LEN_W    = 8,
  parameter int STRIDE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [ADDR_W-1:0]   ring_base_i,
  input  logic [LEN_W-1:0]    ring_len_i,
  input  logic [STRIDE_W-1:0] stride_req_i,
  input  logic                tail_wr_i,
  input  logic [ADDR_W-1:0]   tail_ptr_i,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [31:0]         mem_wdata_o,
  input  logic [31:0]         mem_rdata_i,
  output logic                desc_valid_o,
  output logic [ADDR_W-1:0]   desc_addr_o,
  output logic [127:0]        desc_o,
  output logic                desc_first_o,
  output logic                desc_last_o,
  output logic [2:0]          skip_o,
  output logic                cfg_err_o,
  output logic                suspended_o
);
  import dr_pkg::*;
  localparam int AL = $clog2(BUS_W / 8);

  dr_state_e             state_q, state_d;
  logic [1:0]            wcnt_q;
  logic [3:0][31:0]      dbuf_q;
  logic [ADDR_W-1:0]     tail_q, stride, cur_addr;
  logic                  adv;

  dr_stride_cfg #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .STRIDE_W(STRIDE_W)) u_cfg (
    .stride_req_i(stride_req_i), .skip_o(skip_o), .stride_o(stride), .err_o(cfg_err_o)
  );

  dr_addr_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .AL(AL)) u_agen (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(start_i), .adv_i(adv),
    .base_i(ring_base_i), .len_i(ring_len_i), .stride_i(stride), .addr_o(cur_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tail_q <= '0;
    else if (tail_wr_i) tail_q <= {tail_ptr_i[ADDR_W-1:AL], {AL{1'b0}}};
  end

  always_comb begin
    state_d = state_q;
    adv     = 1'b0;
    unique case (state_q)
      ST_IDLE: if (!cfg_err_o && (cur_addr != tail_q)) state_d = ST_RD;
      ST_RD:   state_d = ST_CAP;
      ST_CAP:  if (wcnt_q == 2'd3) state_d = mem_rdata_i[OWN_BIT] ? ST_SHOW : ST_SUSP;
               else state_d = ST_RD;
      ST_SHOW: state_d = ST_WB;
      ST_WB: begin
        adv     = 1'b1;
        state_d = ST_IDLE;
      end
      ST_SUSP: if (tail_wr_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    if (start_i) state_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wcnt_q  <= '0;
      dbuf_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_CAP) begin
        dbuf_q[wcnt_q] <= mem_rdata_i;
        wcnt_q         <= wcnt_q + 1'b1;
      end
      if (start_i) wcnt_q <= '0;
    end
  end

  always_comb begin
    mem_req_o   = (state_q == ST_RD) || (state_q == ST_WB);
    mem_we_o    = (state_q == ST_WB);
    mem_addr_o  = mem_we_o ? cur_addr + ADDR_W'(12) : cur_addr + ADDR_W'({wcnt_q, 2'b00});
    mem_wdata_o = {1'b0, dbuf_q[3][OWN_BIT-1:0]};
  end

  assign desc_valid_o = (state_q == ST_SHOW);
  assign desc_addr_o  = cur_addr;
  assign desc_o       = dbuf_q;
  assign desc_first_o = dbuf_q[3][FIRST_BIT];
  assign desc_last_o  = dbuf_q[3][LAST_BIT];
  assign suspended_o  = (state_q == ST_SUSP);
endmodule

// File: rtl/dr_ring_seq_chk.sv
module dr_ring_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int BUS_W  = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [31:0]       mem_wdata_o,
  input logic              desc_valid_o,
  input logic [ADDR_W-1:0] desc_addr_o,
  input logic              suspended_o
);
  localparam int BPW = BUS_W / 8;

  a_r4_word_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[1:0] == 2'b00);
  a_r4_single_show: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o |=> !desc_valid_o);
  a_r6_wb_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o |=> mem_we_o);
  a_r6_wb_own_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_addr_o == desc_addr_o + ADDR_W'(12)) && !mem_wdata_o[31]);
  a_r5_suspend_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suspended_o |-> !mem_req_o && !desc_valid_o);
  a_r7_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o - desc_addr_o) < ADDR_W'(16));
  a_r3_desc_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_addr_o & ADDR_W'(BPW - 1)) == '0);
endmodule

bind dr_ring_seq dr_ring_seq_chk #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
  .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .desc_valid_o(desc_valid_o),
  .desc_addr_o(desc_addr_o), .suspended_o(suspended_o)
);

// File: tb/dr_ring_seq_tb.sv
module dr_ring_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BPW = 8;

  logic clk = 0, rst_n = 0;
  logic start = 0, tail_wr = 0;
  logic [31:0] base = 0, tail = 0;
  logic [7:0] len = 4, sreq = 64;
  logic mem_req, mem_we, desc_valid, first, last, cfg_err, susp;
  logic [31:0] mem_addr, mem_wdata, desc_addr;
  logic [31:0] mem_rdata = 0;
  logic [127:0] desc;
  logic [2:0] skip;

  logic [31:0] mem [0:1023];
  logic tb_we = 0;
  logic [31:0] tb_waddr = 0, tb_wdata = 0;

  int total = 0, bad = 0;
  int n_valid = 0, ei = 0, acc_n = 0, bad_acc = 0;
  logic [31:0] bb = 0, bs = 64, bl = 4;

  always #(CLK_PERIOD/2) clk = ~clk;

  dr_ring_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ring_base_i(base), .ring_len_i(len),
    .stride_req_i(sreq), .tail_wr_i(tail_wr), .tail_ptr_i(tail),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .desc_valid_o(desc_valid), .desc_addr_o(desc_addr),
    .desc_o(desc), .desc_first_o(first), .desc_last_o(last), .skip_o(skip),
    .cfg_err_o(cfg_err), .suspended_o(susp)
  );

  always @(posedge clk) begin
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[11:2]];
    if (mem_req && mem_we) mem[mem_addr[11:2]] <= mem_wdata;
    else if (tb_we) mem[tb_waddr[11:2]] <= tb_wdata;
  end

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %0h exp %0h", tag, act, exp);
    end
  endtask

  // monitor: R4 contents/flags, R7/R8 addresses, R7 window
  always @(negedge clk) if (rst_n) begin
    if (desc_valid) begin
      logic [31:0] ea;
      ea = bb + (ei % bl) * bs;
      chk("R8 descriptor address", desc_addr, ea);
      chk("R4 descriptor words", desc,
          {mem[(ea+12)>>2], mem[(ea+8)>>2], mem[(ea+4)>>2], mem[ea>>2]});
      chk("R4 first/last flags", {first, last}, {mem[(ea+12)>>2][29], mem[(ea+12)>>2][28]});
      ei++;
      n_valid++;
    end
    if (mem_req) begin
      logic [31:0] off;
      acc_n++;
      off = (mem_addr - bb) % bs;
      if (off >= 16 || (mem_we && off != 12)) bad_acc++;
    end
  end

  task automatic wr_mem(logic [31:0] a, logic [31:0] d);
    @(negedge clk);
    tb_we = 1; tb_waddr = a; tb_wdata = d;
    @(negedge clk);
    tb_we = 0;
  endtask

  task automatic fill_ring(logic [31:0] b, int n, int s);
    for (int i = 0; i < n; i++) begin
      logic [31:0] a;
      a = b + i * s;
      for (int w = 0; w < 3; w++) wr_mem(a + 4*w, $urandom);
      wr_mem(a + 12, {1'b1, 1'b0, 1'(i % 2 == 0), 1'(i >= n/2), 12'h0, 16'(i)});
    end
  endtask

  task automatic do_start(logic [31:0] b, int n, logic [7:0] s);
    @(negedge clk);
    base = b; len = 8'(n); sreq = s; start = 1;
    bb = {b[31:3], 3'b000}; bl = n; bs = 16 + ((s - 16) / BPW) * BPW; ei = 0;
    @(negedge clk);
    start = 0;
  endtask

  task automatic do_tail(logic [31:0] t);
    @(negedge clk);
    tail = t; tail_wr = 1;
    @(negedge clk);
    tail_wr = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d0w3;
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    idle(3);
    // R10 reset state
    chk("R10 reset outputs", {mem_req, desc_valid, susp}, 3'b000);
    rst_n = 1;
    idle(2);
    chk("R10 quiet after reset", {mem_req, desc_valid, susp}, 3'b000);

    // R1/R2 directed strides
    sreq = 64; #1; chk("R1 stride 64 skip", {cfg_err, skip}, {1'b0, 3'd6});
    sreq = 16; #1; chk("R1 stride 16 skip", {cfg_err, skip}, {1'b0, 3'd0});
    sreq = 72; #1; chk("R1 stride 72 skip", {cfg_err, skip}, {1'b0, 3'd7});
    sreq = 80; #1; chk("R2 stride 80 error", {cfg_err, skip}, {1'b1, 3'd0});
    sreq = 20; #1; chk("R2 stride 20 error", {cfg_err, skip}, {1'b1, 3'd0});
    sreq = 8;  #1; chk("R2 stride 8 error", {cfg_err, skip}, {1'b1, 3'd0});
    for (int k = 0; k < 24; k++) begin
      int s;
      logic e;
      s = $urandom % 256;
      e = (s < 16) || ((s - 16) % BPW != 0) || ((s - 16) / BPW > 7);
      sreq = 8'(s); #1;
      chk("R1 R2 random stride", {cfg_err, skip}, {e, e ? 3'd0 : 3'((s - 16) / BPW)});
    end

    // ring at 0x100, stride 64, 4 entries
    fill_ring(32'h100, 4, 64);
    d0w3 = mem[32'h10C >> 2];
    do_start(32'h105, 4, 64);                 // R3 base low bits dropped
    chk("R10 start loads base", desc_addr, 32'h100);
    do_tail(32'h100 + 2*64 + 3);              // R3 tail low bits dropped
    idle(60);
    chk("R9 stopped at tail", {n_valid, mem_req, susp}, {32'd2, 1'b0, 1'b0});
    chk("R3 R7 stop address", desc_addr, 32'h180);
    chk("R6 own cleared desc0", mem[32'h10C >> 2], d0w3 & 32'h7fff_ffff);
    chk("R6 own cleared desc1", mem[32'h14C >> 2][31], 1'b0);
    chk("R6 untouched desc2", mem[32'h18C >> 2][31], 1'b1);

    do_tail(32'h100);                         // R8 wrap
    idle(60);
    chk("R8 wrapped and stopped", {n_valid, mem_req}, {32'd4, 1'b0});
    chk("R8 address back at base", desc_addr, 32'h100);

    do_tail(32'h140);                         // desc0 no longer owned
    idle(40);
    chk("R5 suspended", {susp, mem_req}, 2'b10);
    chk("R5 nothing presented", n_valid, 4);
    chk("R5 desc0 not written", mem[32'h10C >> 2], d0w3 & 32'h7fff_ffff);
    wr_mem(32'h10C, d0w3);
    idle(10);
    chk("R5 still suspended", susp, 1'b1);
    do_tail(32'h140);
    idle(40);
    chk("R5 resumed after tail write", {susp, n_valid}, {1'b0, 32'd5});
    chk("R9 stop at new tail", desc_addr, 32'h140);

    // R2 no fetch while in error
    begin
      int a0;
      do_start(32'h200, 3, 80);
      chk("R2 error flagged", cfg_err, 1'b1);
      a0 = acc_n;
      do_tail(32'h300);
      idle(40);
      chk("R2 no access in error", acc_n, a0);
    end

    // R1 contiguous ring, stride 16, 3 entries, full wrap
    fill_ring(32'h200, 3, 16);
    do_start(32'h200, 3, 16);
    do_tail(32'h210);
    idle(10);
    do_tail(32'h200);
    idle(80);
    chk("R1 R8 contiguous ring", {n_valid, desc_addr}, {32'd8, 32'h200});

    chk("R7 gap words never accessed", bad_acc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule